// File: doc/BRIEF.md
# Page-Aware Flash Write Sequencer

This block turns a request of the form "write N bytes starting at flash address A" into the command sequence a serial NOR flash needs. It splits the byte stream into chunks of at most four bytes. No chunk crosses a 256-byte page edge, because the flash would otherwise wrap the extra bytes back to the start of the same page. For every chunk it sends a write-enable command, then one page-program command carrying the chunk, then status reads until the write-in-progress bit clears. It then moves to the next chunk.

The sequencer drives a separate command engine that does the serial shifting. The engine takes an opcode, a 24-bit address, transmit and receive byte counts, a data word and a start strobe, and it reports back through a busy flag and a received status byte. The data bytes come from a valid/ready byte stream. A running count of bytes written is available, and a one-cycle pulse marks the end of each request.

The controller uses these states. IDLE waits for a request; taking one moves it to CHECK. CHECK goes to FINISH when the length is zero, to REJECT when the range is too large, and to GATHER otherwise. GATHER collects the chunk's bytes and moves to WREN_GO on the last one. WREN_GO issues write-enable and moves to WREN_WAIT. WREN_WAIT, once the engine is no longer busy, moves to PROG_GO. PROG_GO issues page-program and moves to PROG_WAIT. PROG_WAIT moves to POLL_GO. POLL_GO issues a status read and moves to POLL_WAIT. POLL_WAIT, once the engine is no longer busy, returns to POLL_GO if the status shows the flash still busy, and otherwise moves to ADVANCE. ADVANCE returns to GATHER if bytes remain, or moves to FINISH after the last chunk. FINISH and REJECT both return to IDLE.

Top module: `flash_prog_seq`

## Requirements
- R1: A request is taken only while `req_ready` is high (IDLE). A request with start + length greater than the device size (default 4 MiB) raises `err` for exactly one cycle, issues no command, takes no input byte, and leaves `bytes_written` at 0.
- R2: A request of length zero raises `done` for one cycle, issues no command, and takes no input byte.
- R3: Each chunk length is the smallest of three values: 4, the remaining byte count, and 256 minus (address mod 256).
- R4: Each chunk issues, in this order: a write-enable (opcode 0x06, transmit 1, receive 0); a page-program (opcode 0x02, the chunk address, transmit = chunk length + 4, receive 0); and one or more status reads (opcode 0x05, transmit 1, receive 1).
- R5: The program data word is little-endian. The chunk's first byte is in bits [7:0], the second in [15:8], and so on. Bytes above the chunk length are zero.
- R6: `in_ready` is high only while a chunk is being gathered. Exactly as many bytes are taken as the chunk needs. No byte is taken while a command is outstanding.
- R7: After each chunk the address advances by the chunk length. `bytes_written` ends equal to the request length. `done` is a single-cycle pulse that follows the final status read reporting the flash idle.
- R8: `cmd_start` is raised only while `cmd_busy` is low. A command counts as finished at the first cycle after the start in which `cmd_busy` is low.
- R9: Status reads repeat for as long as bit 0 of `cmd_rdata` is 1. The other status bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_addr | input | ADDR_W | Start flash address |
| req_len | input | ADDR_W+1 | Byte count |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Sequencer takes the byte |
| in_data | input | 8 | Input byte |
| cmd_start | output | 1 | Start strobe to command engine |
| cmd_opcode | output | 8 | Flash opcode |
| cmd_addr | output | ADDR_W | Flash address for the command |
| cmd_tx_cnt | output | CNT_W | Bytes transmitted, opcode included |
| cmd_rx_cnt | output | CNT_W | Bytes received |
| cmd_wdata | output | 8*MAX_CHUNK | Program data word |
| cmd_busy | input | 1 | Command engine busy |
| cmd_rdata | input | 8 | Status byte from the last read |
| done | output | 1 | Request finished |
| err | output | 1 | Request rejected for range |
| bytes_written | output | ADDR_W+1 | Bytes programmed so far in this request |

## Verification
The checker watches every cycle for several things. It flags a start strobe raised while the engine is busy, and a page-program that is not preceded by a write-enable. It checks that each program transmit count lies between 5 and 8 and that the program stays inside its page. It also checks that unused data lanes are zero, that `done` and `err` are single-cycle pulses that never coincide, and that byte intake never overlaps a start strobe. Some behaviour needs the bench's scenarios instead. These include the exact chunk split, the byte packing against the bytes actually fed, the number of status reads against the busy count the engine model chose, and the final byte total. The boundary cases at the page edge and at the device end are also covered only by the bench.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CHECK,
        S_GATHER,
        S_WREN_GO,
        S_WREN_WAIT,
        S_PROG_GO,
        S_PROG_WAIT,
        S_POLL_GO,
        S_POLL_WAIT,
        S_ADVANCE,
        S_FINISH,
        S_REJECT
    } seq_state_t;

    localparam logic [7:0] OP_WREN_DEF = 8'h06;
    localparam logic [7:0] OP_PROG_DEF = 8'h02;
    localparam logic [7:0] OP_STAT_DEF = 8'h05;

endpackage

// File: rtl/chunk_planner.sv
module chunk_planner #(
    parameter int ADDR_W     = 24,
    parameter int PAGE_BYTES = 256,
    parameter int MAX_CHUNK  = 4,
    localparam int LEN_W     = ADDR_W + 1,
    localparam int PAGE_W    = $clog2(PAGE_BYTES),
    localparam int CHUNK_W   = $clog2(MAX_CHUNK + 1)
) (
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic [LEN_W-1:0]   remain,
    output logic [CHUNK_W-1:0] chunk_len
);

    logic [PAGE_W:0] room;

    always_comb begin
        room      = (PAGE_W + 1)'(PAGE_BYTES) - {1'b0, cur_addr[PAGE_W-1:0]};
        chunk_len = CHUNK_W'(MAX_CHUNK);
        if (room < (PAGE_W + 1)'(chunk_len)) begin
            chunk_len = CHUNK_W'(room);
        end
        if (remain < LEN_W'(chunk_len)) begin
            chunk_len = CHUNK_W'(remain);
        end
    end

endmodule

// File: rtl/byte_packer.sv
module byte_packer #(
    parameter int MAX_CHUNK = 4,
    localparam int CHUNK_W  = $clog2(MAX_CHUNK + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   push,
    input  logic [7:0]             push_data,
    output logic [CHUNK_W-1:0]     count,
    output logic [8*MAX_CHUNK-1:0] word
);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (push) begin
            count <= count + CHUNK_W'(1);
        end
    end

    for (genvar lane = 0; lane < MAX_CHUNK; lane++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                word[8*lane +: 8] <= 8'h00;
            end else if (push && count == CHUNK_W'(lane)) begin
                word[8*lane +: 8] <= push_data;
            end
        end
    end

endmodule

// File: rtl/progress_tracker.sv
module progress_tracker #(
    parameter int ADDR_W    = 24,
    parameter int MAX_CHUNK = 4,
    localparam int LEN_W    = ADDR_W + 1,
    localparam int CHUNK_W  = $clog2(MAX_CHUNK + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [ADDR_W-1:0]  load_addr,
    input  logic [LEN_W-1:0]   load_len,
    input  logic               step,
    input  logic [CHUNK_W-1:0] step_len,
    output logic [ADDR_W-1:0]  cur_addr,
    output logic [LEN_W-1:0]   remain,
    output logic [LEN_W-1:0]   written
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
            written  <= '0;
        end else if (load) begin
            cur_addr <= load_addr;
            remain   <= load_len;
            written  <= '0;
        end else if (step) begin
            cur_addr <= cur_addr + ADDR_W'(step_len);
            remain   <= remain - LEN_W'(step_len);
            written  <= written + LEN_W'(step_len);
        end
    end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_seq_pkg::*;
#(
    parameter int         ADDR_W     = 24,
    parameter int         DEV_BYTES  = 4194304,
    parameter int         PAGE_BYTES = 256,
    parameter int         MAX_CHUNK  = 4,
    parameter int         CNT_W      = 4,
    parameter int         WIP_BIT    = 0,
    parameter logic [7:0] OP_WREN    = OP_WREN_DEF,
    parameter logic [7:0] OP_PROG    = OP_PROG_DEF,
    parameter logic [7:0] OP_STAT    = OP_STAT_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [ADDR_W:0]        req_len,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [7:0]             in_data,
    output logic                   cmd_start,
    output logic [7:0]             cmd_opcode,
    output logic [ADDR_W-1:0]      cmd_addr,
    output logic [CNT_W-1:0]       cmd_tx_cnt,
    output logic [CNT_W-1:0]       cmd_rx_cnt,
    output logic [8*MAX_CHUNK-1:0] cmd_wdata,
    input  logic                   cmd_busy,
    input  logic [7:0]             cmd_rdata,
    output logic                   done,
    output logic                   err,
    output logic [ADDR_W:0]        bytes_written
);

    localparam int LEN_W   = ADDR_W + 1;
    localparam int SUM_W   = ADDR_W + 2;
    localparam int CHUNK_W = $clog2(MAX_CHUNK + 1);
    localparam logic [SUM_W-1:0] DEV_LIM = SUM_W'(DEV_BYTES);

    seq_state_t state;
    seq_state_t state_nxt;

    logic [ADDR_W-1:0]      cur_addr;
    logic [LEN_W-1:0]       remain;
    logic [CHUNK_W-1:0]     chunk_len;
    logic [CHUNK_W-1:0]     pk_count;
    logic [8*MAX_CHUNK-1:0] pk_word;
    logic                   load;
    logic                   step;
    logic                   pk_clear;
    logic                   pk_push;
    logic                   over_range;
    logic                   last_byte;
    logic                   last_chunk;
    logic                   flash_busy;

    progress_tracker #(
        .ADDR_W    (ADDR_W),
        .MAX_CHUNK (MAX_CHUNK)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (req_addr),
        .load_len  (req_len),
        .step      (step),
        .step_len  (chunk_len),
        .cur_addr  (cur_addr),
        .remain    (remain),
        .written   (bytes_written)
    );

    chunk_planner #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES),
        .MAX_CHUNK  (MAX_CHUNK)
    ) u_plan (
        .cur_addr  (cur_addr),
        .remain    (remain),
        .chunk_len (chunk_len)
    );

    byte_packer #(
        .MAX_CHUNK (MAX_CHUNK)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (pk_clear),
        .push      (pk_push),
        .push_data (in_data),
        .count     (pk_count),
        .word      (pk_word)
    );

    assign over_range = ({2'b00, cur_addr} + {1'b0, remain}) > DEV_LIM;
    assign last_byte  = (pk_count == chunk_len - CHUNK_W'(1));
    assign last_chunk = (remain == LEN_W'(chunk_len));
    assign flash_busy = cmd_rdata[WIP_BIT];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: begin
                if (req_valid) state_nxt = S_CHECK;
            end
            S_CHECK: begin
                if (remain == '0) begin
                    state_nxt = S_FINISH;
                end else if (over_range) begin
                    state_nxt = S_REJECT;
                end else begin
                    state_nxt = S_GATHER;
                end
            end
            S_GATHER: begin
                if (in_valid && last_byte) state_nxt = S_WREN_GO;
            end
            S_WREN_GO: begin
                if (!cmd_busy) state_nxt = S_WREN_WAIT;
            end
            S_WREN_WAIT: begin
                if (!cmd_busy) state_nxt = S_PROG_GO;
            end
            S_PROG_GO: begin
                if (!cmd_busy) state_nxt = S_PROG_WAIT;
            end
            S_PROG_WAIT: begin
                if (!cmd_busy) state_nxt = S_POLL_GO;
            end
            S_POLL_GO: begin
                if (!cmd_busy) state_nxt = S_POLL_WAIT;
            end
            S_POLL_WAIT: begin
                if (!cmd_busy) state_nxt = flash_busy ? S_POLL_GO : S_ADVANCE;
            end
            S_ADVANCE: begin
                state_nxt = last_chunk ? S_FINISH : S_GATHER;
            end
            S_FINISH: state_nxt = S_IDLE;
            S_REJECT: state_nxt = S_IDLE;
            default:  state_nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        in_ready   = 1'b0;
        cmd_start  = 1'b0;
        cmd_opcode = 8'h00;
        cmd_addr   = '0;
        cmd_tx_cnt = '0;
        cmd_rx_cnt = '0;
        cmd_wdata  = '0;
        done       = 1'b0;
        err        = 1'b0;
        load       = 1'b0;
        step       = 1'b0;
        pk_clear   = 1'b0;
        pk_push    = 1'b0;
        unique case (state)
            S_IDLE: begin
                req_ready = 1'b1;
                load      = req_valid;
            end
            S_CHECK: begin
                pk_clear = 1'b1;
            end
            S_GATHER: begin
                in_ready = 1'b1;
                pk_push  = in_valid;
            end
            S_WREN_GO: begin
                cmd_start  = !cmd_busy;
                cmd_opcode = OP_WREN;
                cmd_tx_cnt = CNT_W'(1);
            end
            S_PROG_GO: begin
                cmd_start  = !cmd_busy;
                cmd_opcode = OP_PROG;
                cmd_addr   = cur_addr;
                cmd_tx_cnt = CNT_W'(chunk_len) + CNT_W'(4);
                cmd_wdata  = pk_word;
            end
            S_POLL_GO: begin
                cmd_start  = !cmd_busy;
                cmd_opcode = OP_STAT;
                cmd_tx_cnt = CNT_W'(1);
                cmd_rx_cnt = CNT_W'(1);
            end
            S_ADVANCE: begin
                step     = 1'b1;
                pk_clear = 1'b1;
            end
            S_FINISH: done = 1'b1;
            S_REJECT: err  = 1'b1;
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
    parameter int         ADDR_W     = 24,
    parameter int         PAGE_BYTES = 256,
    parameter int         MAX_CHUNK  = 4,
    parameter int         CNT_W      = 4,
    parameter logic [7:0] OP_WREN    = 8'h06,
    parameter logic [7:0] OP_PROG    = 8'h02
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_ready,
    input logic                   cmd_start,
    input logic [7:0]             cmd_opcode,
    input logic [ADDR_W-1:0]      cmd_addr,
    input logic [CNT_W-1:0]       cmd_tx_cnt,
    input logic [8*MAX_CHUNK-1:0] cmd_wdata,
    input logic                   cmd_busy,
    input logic                   done,
    input logic                   err
);

    localparam int PAGE_W = $clog2(PAGE_BYTES);

    logic wren_armed;
    logic prog_go;

    assign prog_go = cmd_start && (cmd_opcode == OP_PROG);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wren_armed <= 1'b0;
        end else if (cmd_start && cmd_opcode == OP_WREN) begin
            wren_armed <= 1'b1;
        end else if (prog_go) begin
            wren_armed <= 1'b0;
        end
    end

    // R8
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> !cmd_busy);

    // R4
    wren_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> wren_armed);

    // R3
    prog_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> (int'(cmd_tx_cnt) >= 5) && (int'(cmd_tx_cnt) <= MAX_CHUNK + 4)
                    && (int'(cmd_addr[PAGE_W-1:0]) + int'(cmd_tx_cnt) - 4 <= PAGE_BYTES));

    // R5
    lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_go && int'(cmd_tx_cnt) < MAX_CHUNK + 4)
        |-> ((cmd_wdata >> (8 * (int'(cmd_tx_cnt) - 4))) == '0));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !done ##1 !err);

    // R6
    intake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !cmd_start && !cmd_busy);

endmodule

bind flash_prog_seq flash_prog_seq_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .MAX_CHUNK  (MAX_CHUNK),
    .CNT_W      (CNT_W),
    .OP_WREN    (OP_WREN),
    .OP_PROG    (OP_PROG)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .cmd_start  (cmd_start),
    .cmd_opcode (cmd_opcode),
    .cmd_addr   (cmd_addr),
    .cmd_tx_cnt (cmd_tx_cnt),
    .cmd_wdata  (cmd_wdata),
    .cmd_busy   (cmd_busy),
    .done       (done),
    .err        (err)
);

// File: tb/sim_flash_prog_seq.sv
module sim_flash_prog_seq;

    localparam int SIZE = 4194304;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [24:0] req_len = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        cmd_start;
    logic [7:0]  cmd_opcode;
    logic [23:0] cmd_addr;
    logic [3:0]  cmd_tx_cnt;
    logic [3:0]  cmd_rx_cnt;
    logic [31:0] cmd_wdata;
    logic        cmd_busy;
    logic [7:0]  cmd_rdata;
    logic        done;
    logic        err;
    logic [24:0] bytes_written;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int log_n = 0;
    int bcnt = 0;
    int wip_left = 0;

    logic [7:0]  lg_op   [0:255];
    logic [23:0] lg_addr [0:255];
    logic [3:0]  lg_tx   [0:255];
    logic [3:0]  lg_rx   [0:255];
    logic [31:0] lg_data [0:255];
    int          lg_plan [0:255];
    logic [7:0]  src     [0:63];

    flash_prog_seq u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_len       (req_len),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_data       (in_data),
        .cmd_start     (cmd_start),
        .cmd_opcode    (cmd_opcode),
        .cmd_addr      (cmd_addr),
        .cmd_tx_cnt    (cmd_tx_cnt),
        .cmd_rx_cnt    (cmd_rx_cnt),
        .cmd_wdata     (cmd_wdata),
        .cmd_busy      (cmd_busy),
        .cmd_rdata     (cmd_rdata),
        .done          (done),
        .err           (err),
        .bytes_written (bytes_written)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // command engine model: logs every command, busy for 1..3 cycles,
    // reports write-in-progress for a random number of status reads
    always @(posedge clk) begin
        if (!rst_n) begin
            cmd_busy  <= 1'b0;
            cmd_rdata <= 8'h00;
            bcnt = 0;
            wip_left = 0;
        end else if (cmd_start) begin
            // R8
            if (cmd_busy) begin
                fails++;
                $display("FAIL R8 start while busy: actual 1 expected 0");
            end
            if (log_n < 256) begin
                lg_op[log_n]   = cmd_opcode;
                lg_addr[log_n] = cmd_addr;
                lg_tx[log_n]   = cmd_tx_cnt;
                lg_rx[log_n]   = cmd_rx_cnt;
                lg_data[log_n] = cmd_wdata;
                lg_plan[log_n] = 0;
                if (cmd_opcode == 8'h02) begin
                    lg_plan[log_n] = int'($urandom % 4);
                    wip_left = lg_plan[log_n];
                end
                if (cmd_opcode == 8'h05) begin
                    // R9: upper status bits random, only bit 0 counts
                    cmd_rdata <= {7'($urandom), (wip_left > 0)};
                    if (wip_left > 0) wip_left--;
                end
                log_n++;
            end
            cmd_busy <= 1'b1;
            bcnt = int'($urandom % 3);
        end else if (cmd_busy) begin
            if (bcnt == 0) cmd_busy <= 1'b0;
            else bcnt--;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic int exp_chunk(input int a, input int rem);
        int c = 4;
        if (256 - (a % 256) < c) c = 256 - (a % 256);
        if (rem < c) c = rem;
        return c;
    endfunction

    function automatic logic [31:0] exp_pack(input int p, input int c);
        logic [31:0] w = '0;
        for (int i = 0; i < c; i++) w[8*i +: 8] = src[p + i];
        return w;
    endfunction

    task automatic feed(input int n, input int gapmax);
        for (int i = 0; i < n; i++) begin
            int g = (gapmax > 0) ? int'($urandom % (gapmax + 1)) : 0;
            if (g > 0) begin
                in_valid = 1'b0;
                repeat (g) @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = src[i];
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic run(input int a, input int len, input int gapmax);
        bit exp_err = (len != 0) && (a + len > SIZE);
        bit got_done = 1'b0;
        bit got_err = 1'b0;
        int idx = 0;
        int rem = len;
        int ca = a;
        int p = 0;
        for (int i = 0; i < 64; i++) src[i] = 8'($urandom);
        log_n = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 24'(a);
        req_len   = 25'(len);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        fork
            begin
                if (!exp_err && len > 0) feed(len, gapmax);
            end
            begin
                for (int k = 0; k < 20000; k++) begin
                    if (done || err) break;
                    @(negedge clk);
                end
                got_done = done;
                got_err  = err;
            end
        join
        @(negedge clk);
        // R7 / R1: single-cycle pulses, back to idle
        check(!done && !err, "R7", "end pulse width", {done, err}, 0);
        check(req_ready && !in_ready, "R1", "idle after end", {req_ready, in_ready}, 2);
        if (exp_err) begin
            check(got_err && !got_done, "R1", "range reject", {got_err, got_done}, 2);
            check(log_n == 0, "R1", "no traffic on reject", log_n, 0);
            check(bytes_written == 0, "R1", "written on reject", bytes_written, 0);
        end else if (len == 0) begin
            check(got_done && !got_err, "R2", "zero length done", {got_done, got_err}, 2);
            check(log_n == 0, "R2", "no traffic on zero length", log_n, 0);
        end else begin
            check(got_done && !got_err, "R7", "done raised", {got_done, got_err}, 2);
            while (rem > 0) begin
                int c = exp_chunk(ca, rem);
                int polls;
                check(lg_op[idx] == 8'h06 && lg_tx[idx] == 4'd1 && lg_rx[idx] == 4'd0,
                      "R4", "write enable", {lg_op[idx], lg_tx[idx], lg_rx[idx]}, 'h0610);
                idx++;
                check(lg_op[idx] == 8'h02 && lg_rx[idx] == 4'd0, "R4", "program opcode",
                      lg_op[idx], 'h02);
                check(int'(lg_tx[idx]) == c + 4, "R3", "program tx count", lg_tx[idx], c + 4);
                check(int'(lg_addr[idx]) == ca, "R7", "chunk address", lg_addr[idx], ca);
                check(lg_data[idx] == exp_pack(p, c), "R5", "packed data",
                      lg_data[idx], exp_pack(p, c));
                polls = lg_plan[idx] + 1;
                idx++;
                for (int q = 0; q < polls; q++) begin
                    check(lg_op[idx] == 8'h05 && lg_tx[idx] == 4'd1 && lg_rx[idx] == 4'd1,
                          "R9", "status read", {lg_op[idx], lg_tx[idx], lg_rx[idx]}, 'h0511);
                    idx++;
                end
                ca  += c;
                rem -= c;
                p   += c;
            end
            check(idx == log_n, "R6", "command count", log_n, idx);
            check(int'(bytes_written) == len, "R7", "bytes written", bytes_written, len);
        end
    endtask

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        // reset state
        check(req_ready && !in_ready && !cmd_start && !done && !err && bytes_written == 0,
              "R1", "reset outputs", {req_ready, in_ready, cmd_start, done, err}, 'h10);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        run(255, 1, 0);             // R3 single byte at page end
        run(510, 10, 1);            // R3 split 2,4,4 across page edge
        run(4096, 4, 0);            // aligned full chunk
        run(1021, 7, 2);            // R3 split 3,4
        run(300, 0, 0);             // R2 zero length
        run(SIZE - 4, 4, 0);        // R1 ends exactly at device end
        run(SIZE - 3, 4, 0);        // R1 one byte past the end
        run(SIZE, 1, 0);            // R1 start at the end
        run(SIZE - 1, 0, 0);        // R2 zero length at the end
        // random mix near page edges
        for (int t = 0; t < 40; t++) begin
            int pg  = int'($urandom % (SIZE / 256));
            int off = ($urandom % 2 == 0) ? int'(248 + $urandom % 8) : int'($urandom % 256);
            int len = int'($urandom % 25);
            run(pg * 256 + off, len, int'($urandom % 3));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule